// File: doc/BRIEF.md
# Dual-Domain Interrupt Control Unit

A byte-wide register block that collects interrupt sources for a host CPU into two domains. The system domain covers bus failure, a multifunction peripheral, a serial controller, vertical and horizontal video sync and a software interrupt. The VME domain covers request lines IRQ1 to IRQ7. Each domain has a pending-status register, which latches rising edges of its sources, and a mask register. A domain's request output is raised while any pending bit is also enabled in its mask.

Software raises an interrupt in either domain by writing a latch that stays set until software writes it back to zero. Two general-purpose byte registers sit in the same map. Reading a domain's mask register clears every pending bit of that domain. Interrupt service therefore reads status, then mask. The peripheral and serial interrupts also appear on fixed VME lines. External sources pass through a synchronizer before edge detection.

Top module: `irq_ctl_unit`

## Requirements
- R1: Registers sit at odd byte addresses: 1 system mask, 3 system status, 5 system software latch, 7 VME software latch, 9 general register A, 11 general register B, 13 VME mask, 15 VME status. A read of any even address returns 0.
- R2: General registers A and B store all 8 bits written to them and return them on read.
- R3: Mask registers store the written byte with unused bits forced to 0. The system mask keeps bits 7,6,5,4,2,1 and the VME mask keeps bits 7..1.
- R4: A system status bit is set on a rising edge of its source and stays set. The bits are: 7 bus failure, 6 peripheral, 5 serial, 4 vertical sync, 2 horizontal sync, 1 software latch. A source held high does not set a bit again after it is cleared. Bits 3 and 0 are always 0.
- R5: VME status bit k (k = 1..7) is set on a rising edge of request line k. The peripheral interrupt is also ORed into line 6, the serial interrupt into line 5 and the VME software latch into line 3. Bit 0 is always 0.
- R6: A write to a software latch address loads write-data bit 0 into that latch. The latch holds its value until the next write to it, and a read returns it in bit 0.
- R7: A read of a domain's mask address clears that domain's status and leaves the other domain unchanged. A read of a status address clears nothing. If a new rising edge arrives in the same cycle as the clear, that bit stays set.
- R8: Writes to the status addresses have no effect.
- R9: Each domain's request output is high exactly when its status AND its mask is non-zero.
- R10: The active-low asynchronous reset clears masks, statuses, software latches, general registers and read data, and both request outputs go low.
- R11: Read data is registered. The value addressed in a cycle with the read strobe high appears on the read-data output after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| bus_fail_i | input | 1 | Bus failure source |
| periph_irq_i | input | 1 | Multifunction peripheral interrupt |
| serial_irq_i | input | 1 | Serial controller interrupt |
| vsync_i | input | 1 | Vertical sync |
| hsync_i | input | 1 | Horizontal sync |
| vme_req_i | input | 7 | VME request lines 7..1 (index = line) |
| sys_irq_o | output | 1 | System domain request |
| vme_irq_o | output | 1 | VME domain request |

## Verification
The assertions assume a read strobe and a write strobe are never both high in one cycle. Without that, a mask-read clear could hide a status write. They also assume sources are levels that stay high for at least two clocks, so the synchronizer can pass each edge. The stimulus drives one strobe per cycle, changes inputs on the falling clock edge, and holds each source pulse for four cycles. Only the set-versus-clear case places the two events in the same cycle, and it does so with an exact cycle count.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_GP      = 2;

  // register map, odd bytes only
  localparam int A_SYS_MASK = 1;
  localparam int A_SYS_STAT = 3;
  localparam int A_SYS_SOFT = 5;
  localparam int A_VME_SOFT = 7;
  localparam int A_GP0      = 9;
  localparam int A_GP1      = 11;
  localparam int A_VME_MASK = 13;
  localparam int A_VME_STAT = 15;

  localparam logic [7:0] SYS_VALID = 8'hF6;
  localparam logic [7:0] VME_VALID = 8'hFE;

  localparam int SB_FAIL = 7;
  localparam int SB_PER  = 6;
  localparam int SB_SER  = 5;
  localparam int SB_VS   = 4;
  localparam int SB_HS   = 2;
  localparam int SB_SW   = 1;
  localparam int VB_PER  = 6;
  localparam int VB_SER  = 5;
  localparam int VB_SW   = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_domain.sv
module irq_domain #(
  parameter int           W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  input  logic         clr_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] rise_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, status_q, mask_q, status_d;

  assign rise_o = lvl_i & ~prev_q & VALID;

  // a fresh edge beats a same-cycle clear
  assign status_d = (clr_i ? '0 : status_q) | rise_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      prev_q   <= lvl_i;
      status_q <= status_d;
      if (mask_we_i) mask_q <= mask_wd_i & VALID;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
  import irq_ctl_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int SYNC  = SYNC_STAGES,
  parameter int N_GP  = NUM_GP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          bus_fail_i,
  input  logic          periph_irq_i,
  input  logic          serial_irq_i,
  input  logic          vsync_i,
  input  logic          hsync_i,
  input  logic [7:1]    vme_req_i,
  output logic          sys_irq_o,
  output logic          vme_irq_o
);
  localparam int EXT_W = 12;

  logic [EXT_W-1:0] ext_raw, ext_s;
  logic [DW-1:0]    sys_lvl, vme_lvl;
  logic [DW-1:0]    sys_mask, sys_status, sys_rise;
  logic [DW-1:0]    vme_mask, vme_status, vme_rise;
  logic [DW-1:0]    gp_q [N_GP];
  logic [DW-1:0]    rd_val, rdata_q;
  logic             sys_sw_q, vme_sw_q;
  logic             sys_clr, vme_clr;

  assign ext_raw = {vme_req_i, hsync_i, vsync_i, serial_irq_i, periph_irq_i, bus_fail_i};

  irq_sync #(.W(EXT_W), .STAGES(SYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_raw), .q_o(ext_s)
  );

  always_comb begin
    sys_lvl          = '0;
    sys_lvl[SB_FAIL] = ext_s[0];
    sys_lvl[SB_PER]  = ext_s[1];
    sys_lvl[SB_SER]  = ext_s[2];
    sys_lvl[SB_VS]   = ext_s[3];
    sys_lvl[SB_HS]   = ext_s[4];
    sys_lvl[SB_SW]   = sys_sw_q;
    vme_lvl          = '0;
    vme_lvl[7:1]     = ext_s[11:5];
    vme_lvl[VB_PER]  = ext_s[11:5][VB_PER-1] | ext_s[1];
    vme_lvl[VB_SER]  = ext_s[11:5][VB_SER-1] | ext_s[2];
    vme_lvl[VB_SW]   = ext_s[11:5][VB_SW-1]  | vme_sw_q;
  end

  assign sys_clr = rd_i && (addr_i == AW'(A_SYS_MASK));
  assign vme_clr = rd_i && (addr_i == AW'(A_VME_MASK));

  irq_domain #(.W(DW), .VALID(DW'(SYS_VALID))) u_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sys_lvl),
    .mask_we_i(wr_i && (addr_i == AW'(A_SYS_MASK))), .mask_wd_i(wdata_i),
    .clr_i(sys_clr), .mask_o(sys_mask), .status_o(sys_status),
    .rise_o(sys_rise), .irq_o(sys_irq_o)
  );

  irq_domain #(.W(DW), .VALID(DW'(VME_VALID))) u_vme (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(vme_lvl),
    .mask_we_i(wr_i && (addr_i == AW'(A_VME_MASK))), .mask_wd_i(wdata_i),
    .clr_i(vme_clr), .mask_o(vme_mask), .status_o(vme_status),
    .rise_o(vme_rise), .irq_o(vme_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_sw_q <= 1'b0;
      vme_sw_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == AW'(A_SYS_SOFT)) sys_sw_q <= wdata_i[0];
      if (addr_i == AW'(A_VME_SOFT)) vme_sw_q <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < N_GP; g++) begin : g_gp
    localparam int GP_ADDR = A_GP0 + 2 * g;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                gp_q[g] <= '0;
      else if (wr_i && (addr_i == AW'(GP_ADDR))) gp_q[g] <= wdata_i;
    end
  end

  always_comb begin
    case (int'(addr_i))
      A_SYS_MASK: rd_val = sys_mask;
      A_SYS_STAT: rd_val = sys_status;
      A_SYS_SOFT: rd_val = DW'(sys_sw_q);
      A_VME_SOFT: rd_val = DW'(vme_sw_q);
      A_GP0:      rd_val = gp_q[0];
      A_GP1:      rd_val = gp_q[1];
      A_VME_MASK: rd_val = vme_mask;
      A_VME_STAT: rd_val = vme_status;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
  import irq_ctl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  sys_status,
  input logic [7:0]  vme_status,
  input logic [7:0]  sys_rise,
  input logic [7:0]  vme_rise,
  input logic [7:0]  gp0,
  input logic        sys_sw
);
  // R7
  sys_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'(A_SYS_MASK) && sys_rise == 8'h00) |=> sys_status == 8'h00);

  // R7
  sys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == 4'(A_SYS_MASK)) |=> ((sys_status & $past(sys_status)) == $past(sys_status)));

  // R4
  sys_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rise != 8'h00) |=> ((sys_status & $past(sys_rise)) == $past(sys_rise)));

  // R4
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_status[3] == 1'b0) && (sys_status[0] == 1'b0) && (vme_status[0] == 1'b0));

  // R8
  stat_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == 4'(A_VME_STAT) && vme_rise == 8'h00) |=> $stable(vme_status));

  // R2
  gp_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'(A_GP0)) |=> gp0 == $past(wdata_i));

  // R6
  soft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 4'(A_SYS_SOFT)) |=> $stable(sys_sw));
endmodule

bind irq_ctl_unit irq_ctl_chk u_irq_ctl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .sys_status(sys_status), .vme_status(vme_status),
  .sys_rise(sys_rise), .vme_rise(vme_rise), .gp0(gp_q[0]), .sys_sw(sys_sw_q)
);

// File: tb/irq_ctl_unit_bench.sv
`timescale 1ns/1ps
module irq_ctl_unit_bench;
  localparam real T_CLK = 8.0;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       fail_s = 0, per_s = 0, ser_s = 0, vs_s = 0, hs_s = 0;
  logic [7:1] vme_s = '0;
  logic       sys_irq, vme_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(T_CLK/2) clk = ~clk;

  irq_ctl_unit u_irq_ctl_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .bus_fail_i(fail_s), .periph_irq_i(per_s),
    .serial_irq_i(ser_s), .vsync_i(vs_s), .hsync_i(hs_s), .vme_req_i(vme_s),
    .sys_irq_o(sys_irq), .vme_irq_o(vme_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [7:0] d);
    addr = 4'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(string req, int a, logic [7:0] exp);
    logic [7:0] d;
    rd_reg(a, d);
    check(req, d, exp);
  endtask

  task automatic set_sys_src(int idx, logic v);
    case (idx)
      0: fail_s = v;
      1: per_s  = v;
      2: ser_s  = v;
      3: vs_s   = v;
      default: hs_s = v;
    endcase
  endtask

  function automatic logic [7:0] sys_bit(int idx);
    case (idx)
      0: return 8'h80;
      1: return 8'h40;
      2: return 8'h20;
      3: return 8'h10;
      default: return 8'h04;
    endcase
  endfunction

  initial begin
    #(T_CLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, vb;
    idle(3);
    // R10: outputs during reset
    check("R10 rdata in reset", rdata, 8'h00);
    check("R10 irq in reset", {6'b0, sys_irq, vme_irq}, 8'h00);
    rst_n = 1'b1;
    idle(2);
    for (int a = 0; a < 16; a++) rd_chk("R10 reg after reset", a, 8'h00);

    // R8: status writes ignored
    wr_reg(3, 8'hFF);
    wr_reg(15, 8'hFF);
    rd_chk("R8 sys status write", 3, 8'h00);
    rd_chk("R8 vme status write", 15, 8'h00);
    check("R8 irq after status write", {6'b0, sys_irq, vme_irq}, 8'h00);

    // R2: full sweep of both general registers
    for (int v = 0; v < 256; v++) begin
      wr_reg(9, 8'(v));
      wr_reg(11, ~8'(v));
      rd_chk("R2 gp A", 9, 8'(v));
      rd_chk("R2 gp B", 11, ~8'(v));
    end

    // R3: mask storage with unused bits dropped
    wr_reg(1, 8'hFF);
    wr_reg(13, 8'hFF);
    rd_chk("R3 sys mask", 1, 8'hF6);
    rd_chk("R3 vme mask", 13, 8'hFE);
    wr_reg(1, 8'h09);
    rd_chk("R3 sys mask unused", 1, 8'h00);

    // R1: even addresses read zero with every register non-zero
    wr_reg(1, 8'hFF);
    for (int a = 0; a < 16; a += 2) rd_chk("R1 filler", a, 8'h00);
    rd_chk("R1 gp A location", 9, 8'hFF);
    rd_chk("R1 sys mask location", 1, 8'hF6);

    // R4 R5 R9 R7: each system source
    for (int i = 0; i < 5; i++) begin
      b  = sys_bit(i);
      vb = (i == 1) ? 8'h40 : (i == 2) ? 8'h20 : 8'h00;
      set_sys_src(i, 1'b1); idle(4);
      set_sys_src(i, 1'b0); idle(4);
      wr_reg(1, ~b);
      check("R9 sys irq masked off", {7'b0, sys_irq}, 8'h00);
      wr_reg(1, b);
      check("R9 sys irq enabled", {7'b0, sys_irq}, 8'h01);
      wr_reg(13, 8'hFE);
      check("R9 vme irq from sys source", {7'b0, vme_irq}, {7'b0, |vb});
      rd_chk("R4 sys status bit", 3, b);
      rd_chk("R5 vme shared bit", 15, vb);
      rd_chk("R7 status read no clear", 3, b);
      rd_chk("R7 sys mask read", 1, b);
      rd_chk("R7 sys cleared", 3, 8'h00);
      check("R9 sys irq after clear", {7'b0, sys_irq}, 8'h00);
      rd_chk("R7 vme untouched by sys clear", 15, vb);
      rd_chk("R7 vme mask read", 13, 8'hFE);
      rd_chk("R7 vme cleared", 15, 8'h00);
    end

    // R5: each VME line
    for (int k = 1; k < 8; k++) begin
      vme_s[k] = 1'b1; idle(4);
      vme_s[k] = 1'b0; idle(4);
      wr_reg(13, ~(8'(1) << k));
      check("R9 vme irq masked off", {7'b0, vme_irq}, 8'h00);
      wr_reg(13, 8'(1) << k);
      check("R9 vme irq enabled", {7'b0, vme_irq}, 8'h01);
      rd_chk("R5 vme line bit", 15, 8'(1) << k);
      rd_chk("R5 sys unaffected", 3, 8'h00);
      rd_chk("R7 vme mask read", 13, 8'(1) << k);
      rd_chk("R7 vme cleared", 15, 8'h00);
    end

    // R4: level held high sets only once
    hs_s = 1'b1; idle(4);
    rd_chk("R4 held source set", 3, 8'h04);
    rd_chk("R7 clear with held source", 1, 8'h04);
    idle(4);
    rd_chk("R4 held source no reset", 3, 8'h00);
    hs_s = 1'b0; idle(4);

    // R6: software latches
    wr_reg(5, 8'hFF);
    idle(1);
    rd_chk("R6 sys soft readback", 5, 8'h01);
    rd_chk("R4 sys soft status", 3, 8'h02);
    rd_chk("R7 clear sys soft", 1, 8'h04);
    idle(3);
    rd_chk("R6 sys soft stays set", 5, 8'h01);
    rd_chk("R6 no retrigger", 3, 8'h00);
    wr_reg(5, 8'hFE);
    rd_chk("R6 sys soft removed", 5, 8'h00);
    wr_reg(7, 8'h01);
    idle(1);
    rd_chk("R6 vme soft readback", 7, 8'h01);
    rd_chk("R5 vme soft on line 3", 15, 8'h08);
    wr_reg(7, 8'h00);
    rd_chk("R6 vme soft removed", 7, 8'h00);

    // R7: edge and clear in the same cycle, edge wins
    wr_reg(5, 8'h01);
    rd_chk("R7 mask read on set cycle", 1, 8'h04);
    rd_chk("R7 set wins", 3, 8'h02);
    wr_reg(5, 8'h00);

    // R11: read data holds until the next read
    rd_chk("R11 read gp B", 11, 8'h00);
    wr_reg(9, 8'h5A);
    idle(2);
    check("R11 rdata held", rdata, 8'h00);
    rd_chk("R11 new read", 9, 8'h5A);

    // R10: reset mid-run
    wr_reg(1, 8'hFF);
    check("R9 pending sys irq", {7'b0, sys_irq}, 8'h01);
    rst_n = 1'b0;
    idle(2);
    check("R10 irq cleared", {6'b0, sys_irq, vme_irq}, 8'h00);
    rst_n = 1'b1;
    idle(2);
    for (int a = 0; a < 16; a++) rd_chk("R10 reg after second reset", a, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule